// File: doc/BRIEF.md
# DMA Page Translation Walker

This block turns a 32-bit address issued by a DMA-capable device into a physical memory address. Software places a flat table of 8-byte entries in memory and tells the block where it starts and how many bytes it spans. Each entry begins with a 32-bit frame word, followed by a 32-bit word the block never reads. Each translation request selects one entry by its 4 KiB page index. The block checks that index against the table bound and fetches the frame word with a single memory read. It then returns the physical address with read/write permission, or a fault.

There is no caching, so every request costs exactly one table read or none. A request whose index falls outside the table faults at once, without touching memory. The table base and limit reset to zero, so every request faults until software programs the table.

Top module: `dma_page_walker`

## Requirements
- R1: After reset, both table registers read zero. `req_ready_o` is high, and `rsp_valid_o` and `mem_req_valid_o` are low. A request issued before the table is programmed faults.
- R2: Register word address 0 holds the table base and word address 1 holds the table limit. `reg_wr_i` writes `reg_wdata_i` at the selected address, and `reg_rdata_o` shows the selected register at once. Word addresses 2 and 3 read zero, and writes to them change neither register.
- R3: The page index is `req_laddr_i[31:12]`. A table read happens only when the index is less than the limit shifted right by 3, so the three low limit bits have no effect. Otherwise the result is a fault with no memory read, and `rsp_valid_o` rises in the cycle after acceptance.
- R4: The entry address is the base with bit 31 forced to zero, plus the page index times 8, taken modulo 2^32. Each in-range request issues exactly one read, on an 8-byte-aligned address.
- R5: On a read without error, `rsp_paddr_o` is the frame word's bits 31:12 followed by `req_laddr_i[11:0]`, and `rsp_fault_o` is 0. `rsp_perm_o` is 2'b11, where bit 0 grants read and bit 1 grants write.
- R6: A read response with `mem_rsp_err_i` set gives `rsp_fault_o`=1.
- R7: `req_ready_o` is low from acceptance until the result is taken. The result holds stable while `rsp_ready_i` is low. `mem_req_valid_o` and `mem_req_addr_o` hold until `mem_req_ready_i`.
- R8: The base and limit are captured when a request is accepted. Register writes made while that request is in flight do not change its result.
- R9: Every faulting result carries `rsp_perm_o`=2'b00 and `rsp_paddr_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker can accept a request |
| req_laddr_i | input | 32 | Device-side address to translate |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result taken |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_perm_o | output | 2 | Granted access, bit 0 read, bit 1 write |
| rsp_fault_o | output | 1 | Translation fault |
| mem_req_valid_o | output | 1 | Table read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 32 | Byte address of the table entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Walker waits for read data |
| mem_rsp_data_i | input | 32 | Frame word of the entry |
| mem_rsp_err_i | input | 1 | Read failed |

## Verification
The bench covers the limit boundary: the last index below the limit succeeds, and the index equal to it faults without a memory read. A walker that compared with `<=`, or that used the unshifted byte limit, would translate that request or count a stray read. Setting base bit 31 and adding a nonzero offset to the frame word exposes a design that kept the top base bit or passed the frame's low bits through. An error response, a result held back by the consumer, a memory port that stalls its ready, and register writes made during an in-flight walk cover the remaining cases. Each of these catches a result that is stale, unmasked, dropped or changed in flight.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned PAGE_BITS   = 12;
  localparam int unsigned ENTRY_SHIFT = 3;
  localparam int unsigned REG_AW      = 2;

  localparam logic [1:0] PERM_NONE = 2'b00;
  localparam logic [1:0] PERM_RW   = 2'b11;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FETCH = 2'd1,
    W_WAIT  = 2'd2,
    W_DONE  = 2'd3
  } walk_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] paddr;
    logic [1:0]        perm;
    logic              fault;
  } walk_result_t;
endpackage

// File: rtl/dmaw_regs.sv
module dmaw_regs #(
  parameter int unsigned ADDR_W = dmaw_pkg::ADDR_W,
  parameter int unsigned REG_AW = dmaw_pkg::REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] limit_o
);
  localparam logic [REG_AW-1:0] A_BASE  = REG_AW'(0);
  localparam logic [REG_AW-1:0] A_LIMIT = REG_AW'(1);

  logic [ADDR_W-1:0] base_q, limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      limit_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_BASE)  base_q  <= wdata_i;
      if (addr_i == A_LIMIT) limit_q <= wdata_i;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_BASE:  rdata_o = base_q;
      A_LIMIT: rdata_o = limit_q;
      default: rdata_o = '0;
    endcase
  end

  assign base_o  = base_q;
  assign limit_o = limit_q;
endmodule

// File: rtl/dmaw_index.sv
module dmaw_index #(
  parameter int unsigned ADDR_W      = dmaw_pkg::ADDR_W,
  parameter int unsigned PAGE_BITS   = dmaw_pkg::PAGE_BITS,
  parameter int unsigned ENTRY_SHIFT = dmaw_pkg::ENTRY_SHIFT
) (
  input  logic [ADDR_W-1:0]    laddr_i,
  input  logic [ADDR_W-1:0]    base_i,
  input  logic [ADDR_W-1:0]    limit_i,
  output logic                 in_range_o,
  output logic [ADDR_W-1:0]    entry_addr_o,
  output logic [PAGE_BITS-1:0] offset_o
);
  localparam int unsigned IDX_W = ADDR_W - PAGE_BITS;
  localparam int unsigned CNT_W = ADDR_W - ENTRY_SHIFT;

  logic [IDX_W-1:0]  page_idx;
  logic [CNT_W-1:0]  entry_cnt;
  logic [ADDR_W-1:0] base_clr;
  logic [ADDR_W-1:0] idx_bytes;
  logic              unused_ok;

  assign page_idx  = laddr_i[ADDR_W-1:PAGE_BITS];
  assign offset_o  = laddr_i[PAGE_BITS-1:0];
  // byte limit -> number of whole entries
  assign entry_cnt = limit_i[ADDR_W-1:ENTRY_SHIFT];
  assign base_clr  = {1'b0, base_i[ADDR_W-2:0]};
  assign idx_bytes = ADDR_W'({page_idx, {ENTRY_SHIFT{1'b0}}});

  assign in_range_o   = CNT_W'(page_idx) < entry_cnt;
  assign entry_addr_o = base_clr + idx_bytes;

  assign unused_ok = ^{base_i[ADDR_W-1], limit_i[ENTRY_SHIFT-1:0]};
endmodule

// File: rtl/dmaw_fsm.sv
module dmaw_fsm #(
  parameter int unsigned ADDR_W    = dmaw_pkg::ADDR_W,
  parameter int unsigned PAGE_BITS = dmaw_pkg::PAGE_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 in_range_i,
  input  logic [ADDR_W-1:0]    entry_addr_i,
  input  logic [PAGE_BITS-1:0] offset_i,
  output logic                 mem_req_valid_o,
  input  logic                 mem_req_ready_i,
  output logic [ADDR_W-1:0]    mem_req_addr_o,
  input  logic                 mem_rsp_valid_i,
  output logic                 mem_rsp_ready_o,
  input  logic [ADDR_W-1:0]    mem_rsp_data_i,
  input  logic                 mem_rsp_err_i,
  output logic                 rsp_valid_o,
  input  logic                 rsp_ready_i,
  output dmaw_pkg::walk_result_t rsp_o
);
  import dmaw_pkg::*;

  walk_state_e          state_q, state_d;
  logic [ADDR_W-1:0]    ent_q;
  logic [PAGE_BITS-1:0] off_q;
  walk_result_t         res_q, res_d;
  logic                 unused_ok;

  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    unique case (state_q)
      W_IDLE: if (req_valid_i) begin
        if (in_range_i) begin
          state_d = W_FETCH;
        end else begin
          state_d = W_DONE;
          res_d   = '{paddr: '0, perm: PERM_NONE, fault: 1'b1};
        end
      end
      W_FETCH: if (mem_req_ready_i) state_d = W_WAIT;
      W_WAIT: if (mem_rsp_valid_i) begin
        state_d = W_DONE;
        if (mem_rsp_err_i)
          res_d = '{paddr: '0, perm: PERM_NONE, fault: 1'b1};
        else
          res_d = '{paddr: {mem_rsp_data_i[ADDR_W-1:PAGE_BITS], off_q},
                    perm: PERM_RW, fault: 1'b0};
      end
      W_DONE: if (rsp_ready_i) state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= W_IDLE;
      ent_q   <= '0;
      off_q   <= '0;
      res_q   <= '{paddr: '0, perm: PERM_NONE, fault: 1'b0};
    end else begin
      state_q <= state_d;
      res_q   <= res_d;
      if (state_q == W_IDLE && req_valid_i) begin
        ent_q <= entry_addr_i;
        off_q <= offset_i;
      end
    end
  end

  assign req_ready_o     = state_q == W_IDLE;
  assign mem_req_valid_o = state_q == W_FETCH;
  assign mem_req_addr_o  = ent_q;
  assign mem_rsp_ready_o = state_q == W_WAIT;
  assign rsp_valid_o     = state_q == W_DONE;
  assign rsp_o           = res_q;

  assign unused_ok = ^mem_rsp_data_i[PAGE_BITS-1:0];
endmodule

// File: rtl/dma_page_walker.sv
module dma_page_walker #(
  parameter int unsigned ADDR_W      = dmaw_pkg::ADDR_W,
  parameter int unsigned PAGE_BITS   = dmaw_pkg::PAGE_BITS,
  parameter int unsigned ENTRY_SHIFT = dmaw_pkg::ENTRY_SHIFT,
  parameter int unsigned REG_AW      = dmaw_pkg::REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_laddr_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [1:0]        rsp_perm_o,
  output logic              rsp_fault_o,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [ADDR_W-1:0] mem_rsp_data_i,
  input  logic              mem_rsp_err_i
);
  logic [ADDR_W-1:0]      base, limit, entry_addr;
  logic [PAGE_BITS-1:0]   offset;
  logic                   in_range;
  dmaw_pkg::walk_result_t res;

  dmaw_regs #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (base),
    .limit_o (limit)
  );

  dmaw_index #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRY_SHIFT(ENTRY_SHIFT)) u_index (
    .laddr_i      (req_laddr_i),
    .base_i       (base),
    .limit_i      (limit),
    .in_range_o   (in_range),
    .entry_addr_o (entry_addr),
    .offset_o     (offset)
  );

  dmaw_fsm #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .in_range_i      (in_range),
    .entry_addr_i    (entry_addr),
    .offset_i        (offset),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_ready_o (mem_rsp_ready_o),
    .mem_rsp_data_i  (mem_rsp_data_i),
    .mem_rsp_err_i   (mem_rsp_err_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_o           (res)
  );

  assign rsp_paddr_o = res.paddr;
  assign rsp_perm_o  = res.perm;
  assign rsp_fault_o = res.fault;
endmodule

// File: rtl/dma_page_walker_chk.sv
module dma_page_walker_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned ENTRY_SHIFT = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_ready_o,
  input logic [PAGE_BITS-1:0]    req_off_i,
  input logic                    rsp_valid_o,
  input logic                    rsp_ready_i,
  input logic [ADDR_W-1:0]       rsp_paddr_o,
  input logic [1:0]              rsp_perm_o,
  input logic                    rsp_fault_o,
  input logic                    mem_req_valid_o,
  input logic                    mem_req_ready_i,
  input logic [ADDR_W-1:0]       mem_req_addr_o,
  input logic                    mem_rsp_valid_i,
  input logic                    mem_rsp_ready_o,
  input logic [ADDR_W-PAGE_BITS-1:0] mem_rsp_frame_i,
  input logic                    mem_rsp_err_i
);
  logic [PAGE_BITS-1:0] off_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) off_seen <= '0;
    else if (req_valid_i && req_ready_o) off_seen <= req_off_i;
  end

  p_rsp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o)
      && $stable(rsp_perm_o) && $stable(rsp_fault_o));

  p_memreq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  p_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_valid_o || mem_rsp_ready_o) |-> !req_ready_o);

  p_align_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[ENTRY_SHIFT-1:0] == '0);

  p_fault_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_perm_o == 2'b00 && rsp_paddr_o == '0);

  p_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_perm_o == 2'b11
      && rsp_paddr_o[PAGE_BITS-1:0] == off_seen);

  p_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i && mem_rsp_ready_o && !mem_rsp_err_i |=> rsp_valid_o && !rsp_fault_o
      && rsp_paddr_o[ADDR_W-1:PAGE_BITS] == $past(mem_rsp_frame_i));

  p_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_valid_i && mem_rsp_ready_o && mem_rsp_err_i |=> rsp_valid_o && rsp_fault_o);
endmodule

bind dma_page_walker dma_page_walker_chk #(
  .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ENTRY_SHIFT(ENTRY_SHIFT)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_off_i       (req_laddr_i[PAGE_BITS-1:0]),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_paddr_o     (rsp_paddr_o),
  .rsp_perm_o      (rsp_perm_o),
  .rsp_fault_o     (rsp_fault_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_rsp_ready_o (mem_rsp_ready_o),
  .mem_rsp_frame_i (mem_rsp_data_i[ADDR_W-1:PAGE_BITS]),
  .mem_rsp_err_i   (mem_rsp_err_i)
);

// File: tb/dma_page_walker_test.sv
`timescale 1ns/1ps
module dma_page_walker_test;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        reg_wr_i = 0;
  logic [1:0]  reg_addr_i = 0;
  logic [31:0] reg_wdata_i = 0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 0;
  logic        req_ready_o;
  logic [31:0] req_laddr_i = 0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 0;
  logic [31:0] rsp_paddr_o;
  logic [1:0]  rsp_perm_o;
  logic        rsp_fault_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 0;
  logic [31:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 0;
  logic        mem_rsp_ready_o;
  logic [31:0] mem_rsp_data_i = 0;
  logic        mem_rsp_err_i = 0;

  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  dma_page_walker uut (.*);

  // memory model, driven at negedge
  int          mem_reads = 0;
  int          lat = 0, stall = 0, stall_left = 0, cnt = 0;
  bit          pend = 0, req_fire = 0, rsp_fire = 0;
  logic [31:0] fire_addr = 0, last_addr = 0, err_addr = 32'hFFFF_FFFF;

  function automatic logic [31:0] frame_of(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction

  always @(negedge clk_i) begin
    if (rsp_fire) mem_rsp_valid_i = 0;
    if (req_fire) begin
      mem_reads++;
      last_addr = fire_addr;
      cnt = lat;
      pend = 1;
    end
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid_i = 1;
        mem_rsp_data_i  = frame_of(last_addr);
        mem_rsp_err_i   = (last_addr == err_addr);
        pend = 0;
      end else cnt--;
    end
    if (!mem_req_valid_o) begin
      mem_req_ready_i = 0;
      stall_left = stall;
    end else if (stall_left > 0) begin
      mem_req_ready_i = 0;
      stall_left--;
    end else mem_req_ready_i = 1;
    req_fire  = mem_req_valid_o && mem_req_ready_i;
    fire_addr = mem_req_addr_o;
    rsp_fire  = mem_rsp_valid_i && mem_rsp_ready_o;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // issue one request, return result and negedges from accept to result
  task automatic translate(input logic [31:0] la, input int hold,
                           output logic [31:0] pa, output logic [1:0] pm,
                           output logic flt, output int latency);
    req_valid_i = 1; req_laddr_i = la;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
    latency = 0;
    while (!rsp_valid_o) begin
      chk(!req_ready_o, "R7 ready low while busy", {31'b0, req_ready_o}, 0);
      @(negedge clk_i);
      latency++;
    end
    pa = rsp_paddr_o; pm = rsp_perm_o; flt = rsp_fault_o;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk_i);
      chk(rsp_valid_o && rsp_paddr_o == pa && rsp_fault_o == flt,
          "R7 result held", rsp_paddr_o, pa);
      chk(!req_ready_o, "R7 ready low while result pending", {31'b0, req_ready_o}, 0);
    end
    rsp_ready_i = 1;
    @(negedge clk_i);
    rsp_ready_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d, pa; logic [1:0] pm; logic f; int l, r0;
    reg_read(0, d); chk(d == 0, "R1 base reset", d, 0);
    reg_read(1, d); chk(d == 0, "R1 limit reset", d, 0);
    chk(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R1 idle outputs",
        {29'b0, req_ready_o, rsp_valid_o, mem_req_valid_o}, 32'h4);
    r0 = mem_reads;
    translate(32'h0000_0123, 0, pa, pm, f, l);
    chk(f == 1, "R1 unprogrammed faults", {31'b0, f}, 1);
    chk(mem_reads == r0, "R1 no read when unprogrammed", mem_reads, r0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_write(0, 32'hFFFF_F00D); reg_read(0, d); chk(d == 32'hFFFF_F00D, "R2 base rw", d, 32'hFFFF_F00D);
    reg_write(1, 32'h1234_5677); reg_read(1, d); chk(d == 32'h1234_5677, "R2 limit rw", d, 32'h1234_5677);
    reg_write(2, 32'hDEAD_BEEF); reg_write(3, 32'hCAFE_F00D);
    reg_read(2, d); chk(d == 0, "R2 word 2 reads zero", d, 0);
    reg_read(3, d); chk(d == 0, "R2 word 3 reads zero", d, 0);
    reg_read(0, d); chk(d == 32'hFFFF_F00D, "R2 base untouched by stray write", d, 32'hFFFF_F00D);
    reg_read(1, d); chk(d == 32'h1234_5677, "R2 limit untouched by stray write", d, 32'h1234_5677);
  endtask

  task automatic t_limit();
    logic [31:0] pa; logic [1:0] pm; logic f; int l, r0;
    lat = 0; stall = 0;
    reg_write(0, 32'h0001_0000);
    reg_write(1, 32'h0000_0017); // 23 bytes -> 2 entries
    r0 = mem_reads;
    translate(32'h0000_1ABC, 0, pa, pm, f, l);
    chk(f == 0, "R3 last index in range", {31'b0, f}, 0);
    chk(mem_reads == r0 + 1, "R4 one read", mem_reads, r0 + 1);
    chk(last_addr == 32'h0001_0008, "R4 entry address idx 1", last_addr, 32'h0001_0008);
    r0 = mem_reads;
    translate(32'h0000_2000, 0, pa, pm, f, l);
    chk(f == 1, "R3 index equal to bound faults", {31'b0, f}, 1);
    chk(mem_reads == r0, "R3 no read out of range", mem_reads, r0);
    chk(l == 0, "R3 fault result next cycle", l, 0);
    chk(pa == 0 && pm == 0, "R9 fault zeroes", {pa[29:0], pm}, 0);
  endtask

  task automatic t_translate();
    logic [31:0] pa, fr, exp; logic [1:0] pm; logic f; int l;
    reg_write(0, 32'h8004_0000);
    reg_write(1, 32'hFFFF_FFF8);
    lat = 0; stall = 0;
    translate(32'h0003_4567, 0, pa, pm, f, l);
    chk(last_addr == 32'h0004_01A0, "R4 base bit31 cleared", last_addr, 32'h0004_01A0);
    fr = frame_of(32'h0004_01A0); exp = {fr[31:12], 12'h567};
    chk(pa == exp, "R5 frame masked plus offset", pa, exp);
    chk(pm == 2'b11 && f == 0, "R5 read/write granted", {29'b0, f, pm}, 3);
    chk(l == 2, "R5 latency zero-wait memory", l, 2);
    lat = 3; stall = 2;
    translate(32'hFFFF_FFFF, 0, pa, pm, f, l);
    chk(last_addr == 32'h0083_FFF8, "R4 top index", last_addr, 32'h0083_FFF8);
    fr = frame_of(32'h0083_FFF8); exp = {fr[31:12], 12'hFFF};
    chk(pa == exp && f == 0, "R5 top index result", pa, exp);
    chk(l == 7, "R7 latency with memory stall", l, 7);
  endtask

  task automatic t_error();
    logic [31:0] pa; logic [1:0] pm; logic f; int l;
    lat = 1; stall = 0;
    err_addr = 32'h0004_0010;
    translate(32'h0000_2FFF, 0, pa, pm, f, l);
    chk(f == 1, "R6 read error faults", {31'b0, f}, 1);
    chk(pa == 0 && pm == 0, "R9 error result zeroed", pa, 0);
    err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_hold();
    logic [31:0] pa, fr; logic [1:0] pm; logic f; int l;
    lat = 0; stall = 0;
    translate(32'h0000_5004, 3, pa, pm, f, l);
    fr = frame_of(32'h0004_0028);
    chk(pa == {fr[31:12], 12'h004}, "R7 held result value", pa, {fr[31:12], 12'h004});
  endtask

  task automatic t_capture();
    logic [31:0] pa, fr; logic [1:0] pm; logic f; int l;
    lat = 4; stall = 0;
    fork
      translate(32'h0000_6010, 0, pa, pm, f, l);
      begin
        @(negedge clk_i); @(negedge clk_i);
        reg_write(0, 32'h0070_0000);
        reg_write(1, 32'h0000_0000);
      end
    join
    chk(last_addr == 32'h0004_0030, "R8 entry uses captured base", last_addr, 32'h0004_0030);
    fr = frame_of(32'h0004_0030);
    chk(f == 0 && pa == {fr[31:12], 12'h010}, "R8 in-flight result unchanged", pa, {fr[31:12], 12'h010});
    translate(32'h0000_6010, 0, pa, pm, f, l);
    chk(f == 1, "R8 new limit applies to next request", {31'b0, f}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_limit();
    t_translate();
    t_error();
    t_hold();
    t_capture();
    repeat (2) @(negedge clk_i);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule